// File: doc/BRIEF.md
# Strap-Configured Boot Chip-Select Read Controller

This block runs read cycles against an external boot memory. Pins tied high or low on the board (straps) set the bus shape. The block samples them while reset is held, and they do not change until the next reset. One strap picks a separate address bus or a shared address/data bus. A second picks the data width. A third picks a short or a long wait period, and a fourth turns on byte reordering of the returned data.

A requester asks for a read with a valid/ready handshake. The block accepts one request at a time and holds `req_ready` low until the access ends. It drives chip select and output enable, counts wait cycles and stops early if the device acknowledges. It captures the data and returns it on a one-cycle `rsp_valid` pulse. The response side has no back-pressure: the requester must take `rsp_data` in the cycle `rsp_valid` is high.

The block also holds one enable bit for each of several chip selects. Only the boot select (index 0) is enabled out of reset. Software writes the whole enable vector. Clearing bit 0 stops new boot reads from being accepted.

Top module: `boot_cs_ctrl`

## Requirements
- R1: The four straps (`strap_mux`, `strap_size`, `strap_wait`, `strap_swap`) are sampled on every clock edge while `rst_n` is low. Later changes have no effect until the next reset.
- R2: With `strap_mux`=0 and `strap_size`=0, the bus is 8 bits wide. `bus_addr` carries `req_addr[23:0]` (upper bits zero) from the cycle after acceptance until the access ends. The response is `bus_din[7:0]` with zeros above it.
- R3: With `strap_mux`=0 and `strap_size`=1, the bus is 16 bits wide. `bus_addr` carries `req_addr[15:0]`, and the response is taken from `bus_din[15:0]`.
- R4: With `strap_mux`=1, each access starts with exactly one address cycle. In that cycle `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_out`=`req_addr[24:0]`, the chip select is asserted and output enable is not. The shared bus is then released (`bus_ad_oe`=0). Data width is 16 bits when `strap_size`=0 and 32 bits when it is 1.
- R5: Without acknowledge, the wait period lasts 4 cycles (`strap_wait`=0) or 48 cycles (`strap_wait`=1) with `bus_oe_n` low. Data is captured at the end of the last of these cycles.
- R6: `bus_ack` high in a wait cycle captures data at the end of that cycle, before the count runs out. Acknowledge during the address cycle of R4 is ignored.
- R7: With `strap_swap`=1, a 16-bit read returns its two bytes exchanged and a 32-bit read returns its four bytes in reverse order. An 8-bit read is unchanged. With `strap_swap`=0, no read is reordered.
- R8: `rsp_valid` is high for exactly one cycle, in the cycle after capture. Chip select and output enable stay asserted in that cycle and are both deasserted in the next one.
- R9: `cs_enable` resets to 8'h01. When `en_we`=1, it takes `en_wdata`. While bit 0 is clear, `req_ready` is low.
- R10: `req_ready` is high only when no access is in progress. Once a request is accepted, `req_ready` stays low until the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| strap_mux | input | 1 | 0 = separate address bus, 1 = shared address/data bus |
| strap_size | input | 1 | Width select (see R2 to R4) |
| strap_wait | input | 1 | 0 = 4 wait cycles, 1 = 48 wait cycles |
| strap_swap | input | 1 | 1 = byte reordering on reads |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted on a clock edge where valid and ready are both high |
| req_addr | input | 25 | Read address |
| rsp_valid | output | 1 | One-cycle read-done pulse |
| rsp_data | output | 32 | Read data, zero-extended |
| en_we | input | 1 | Chip-select enable write strobe |
| en_wdata | input | 8 | New chip-select enable vector |
| cs_enable | output | 8 | Current chip-select enable vector |
| bus_cs_n | output | 1 | Boot chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_ale | output | 1 | Address latch strobe (shared bus mode) |
| bus_addr | output | 25 | Address lines (separate bus mode) |
| bus_ad_out | output | 32 | Shared bus drive value |
| bus_ad_oe | output | 1 | Shared bus drive enable |
| bus_din | input | 32 | Data returned by the device |
| bus_ack | input | 1 | Early acknowledge from the device |

## Verification
The bench resets the block under all sixteen strap combinations. After each reset it inverts every strap, so any result that depends on the live pins instead of the sampled ones shows up. Each combination runs three reads: one with no acknowledge, one with acknowledge in the first cycle after acceptance, and one with acknowledge in the third cycle. Their latencies separate the wait count from the early exit, and in shared-bus mode they show that acknowledge is ignored during the address cycle. The read data carries a distinct value in every byte, so a wrong width mask, a missing swap or a wrong byte order gives a different value. Writes to the enable vector check that requests are blocked while the boot select is disabled.

// File: rtl/boot_cs_pkg.sv
package boot_cs_pkg;

  typedef struct packed {
    logic mux;
    logic size;
    logic long_wait;
    logic swap;
  } strap_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_END  = 2'd3
  } bstate_t;

  // width code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit
  function automatic logic [1:0] width_code(input strap_cfg_t c);
    if (c.mux) return c.size ? 2'd2 : 2'd1;
    return c.size ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strap_cfg_t straps,
  output strap_cfg_t cfg
);
  // loads while reset is held, frozen once reset is released
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= straps;
  end
endmodule

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int WAIT_SHORT = 4,
  parameter int WAIT_LONG  = 48,
  localparam int CW = $clog2(WAIT_LONG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_sel,
  input  logic ack,
  output logic hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = long_sel ? CW'(WAIT_LONG) : CW'(WAIT_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= CW'(1);
    else if (!run)    cnt <= CW'(1);
    else if (!hit)    cnt <= cnt + CW'(1);
  end

  assign hit = run && (ack || (cnt == limit));
endmodule

// File: rtl/boot_rd_swap.sv
module boot_rd_swap #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic [1:0]        wmode,
  input  logic              swap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rev;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_rev
      assign rev[8*i +: 8] = din[8*(NB-1-i) +: 8];
    end
  endgenerate

  always_comb begin
    dout = '0;
    unique case (wmode)
      2'd0: dout[7:0] = din[7:0];
      2'd1: dout[15:0] = swap ? {din[7:0], din[15:8]} : din[15:0];
      default: dout = swap ? rev : din;
    endcase
  end
endmodule

// File: rtl/boot_cs_enables.sv
module boot_cs_enables #(
  parameter int NUM_CS   = 8,
  parameter int BOOT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NUM_CS-1:0] wdata,
  output logic [NUM_CS-1:0] en
);
  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en[i] <= (i == BOOT_IDX);
        else if (we) en[i] <= wdata[i];
      end
    end
  endgenerate
endmodule

// File: rtl/boot_cs_ctrl.sv
module boot_cs_ctrl
  import boot_cs_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int DATA_W     = 32,
  parameter int NUM_CS     = 8,
  parameter int NM8_AW     = 24,
  parameter int NM16_AW    = 16,
  parameter int WAIT_SHORT = 4,
  parameter int WAIT_LONG  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_mux,
  input  logic              strap_size,
  input  logic              strap_wait,
  input  logic              strap_swap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              en_we,
  input  logic [NUM_CS-1:0] en_wdata,
  output logic [NUM_CS-1:0] cs_enable,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_ale,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ack
);
  localparam logic [ADDR_W-1:0] MASK8  = ADDR_W'((64'd1 << NM8_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] MASK16 = ADDR_W'((64'd1 << NM16_AW) - 64'd1);

  strap_cfg_t        straps, cfg;
  bstate_t           state;
  logic [ADDR_W-1:0] addr_q, amask;
  logic [DATA_W-1:0] swapped;
  logic              fire, hit;

  assign straps = '{mux: strap_mux, size: strap_size,
                    long_wait: strap_wait, swap: strap_swap};

  boot_strap_latch u_straps (
    .clk(clk), .rst_n(rst_n), .straps(straps), .cfg(cfg)
  );

  boot_cs_enables #(.NUM_CS(NUM_CS), .BOOT_IDX(0)) u_en (
    .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(en_wdata), .en(cs_enable)
  );

  boot_wait_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT),
    .long_sel(cfg.long_wait), .ack(bus_ack), .hit(hit)
  );

  boot_rd_swap #(.DATA_W(DATA_W)) u_swap (
    .wmode(width_code(cfg)), .swap(cfg.swap), .din(bus_din), .dout(swapped)
  );

  always_comb begin
    if (cfg.mux)       amask = '1;
    else if (cfg.size) amask = MASK16;
    else               amask = MASK8;
  end

  assign req_ready = (state == ST_IDLE) && cs_enable[0];
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      rsp_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (fire) begin
          addr_q <= req_addr & amask;
          state  <= cfg.mux ? ST_ADDR : ST_WAIT;
        end
        ST_ADDR: state <= ST_WAIT;
        ST_WAIT: if (hit) begin
          rsp_data <= swapped;
          state    <= ST_END;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (state == ST_END);
  assign bus_cs_n   = (state == ST_IDLE);
  assign bus_oe_n   = !((state == ST_WAIT) || (state == ST_END));
  assign bus_ale    = (state == ST_ADDR);
  assign bus_ad_oe  = (state == ST_ADDR);
  assign bus_ad_out = (state == ST_ADDR) ? DATA_W'(addr_q) : '0;
  assign bus_addr   = (!cfg.mux && !bus_oe_n) ? addr_q : '0;
endmodule

// File: rtl/boot_cs_ctrl_chk.sv
module boot_cs_ctrl_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cfg_bits,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] cs_enable,
  input logic              bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_ale,
  input logic              bus_ad_oe
);
  a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_bits));

  a_r4_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (!bus_cs_n && bus_oe_n && bus_ad_oe));

  a_r4_one_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (!bus_ale && !bus_ad_oe));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_held_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!bus_cs_n && !bus_oe_n));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (bus_cs_n && bus_oe_n));

  a_r9_boot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_enable[0] |-> !req_ready);

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind boot_cs_ctrl boot_cs_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bits(cfg), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .cs_enable(cs_enable),
  .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_ale(bus_ale),
  .bus_ad_oe(bus_ad_oe)
);

// File: tb/tb_boot_cs_ctrl.sv
`timescale 1ns/1ps
module tb_boot_cs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_mux = 0, s_size = 0, s_wait = 0, s_swap = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [24:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        en_we = 0;
  logic [7:0]  en_wdata = '0;
  logic [7:0]  cs_enable;
  logic        bus_cs_n, bus_oe_n, bus_ale, bus_ad_oe;
  logic [24:0] bus_addr;
  logic [31:0] bus_ad_out;
  logic [31:0] bus_din = '0;
  logic        bus_ack = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic c_mux, c_size, c_wait, c_swap;

  always #2.5 clk = ~clk;

  boot_cs_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .strap_mux(s_mux), .strap_size(s_size), .strap_wait(s_wait), .strap_swap(s_swap),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .en_we(en_we), .en_wdata(en_wdata), .cs_enable(cs_enable),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_ale(bus_ale),
    .bus_addr(bus_addr), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_din(bus_din), .bus_ack(bus_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [31:0] d);
    logic [31:0] r;
    r = '0;
    if (!c_mux && !c_size)      r[7:0] = d[7:0];
    else if (c_mux && c_size)   r = c_swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    else                        r[15:0] = c_swap ? {d[7:0], d[15:8]} : d[15:0];
    return r;
  endfunction

  function automatic int exp_lat(input int ackat);
    int n, e;
    n = c_wait ? 48 : 4;
    if (!c_mux) e = (ackat == 0) ? n : ((ackat < n) ? ackat : n);
    else begin
      e = (ackat == 0) ? n + 1 : ((ackat < 2) ? 2 : ackat);
      if (e > n + 1) e = n + 1;
    end
    return e + 1;
  endfunction

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    rst_n = 0;
    {s_mux, s_size, s_wait, s_swap} = s;
    {c_mux, c_size, c_wait, c_swap} = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: live straps inverted; behaviour must follow the sampled ones
    {s_mux, s_size, s_wait, s_swap} = ~s;
  endtask

  task automatic txn(input logic [24:0] a, input logic [31:0] d, input int ackat);
    int c;
    string dtag;
    @(negedge clk);
    chk("R10 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1; req_addr = a; bus_din = d;
    @(negedge clk);
    req_valid = 0;
    chk("R10 ready low while busy", 32'(req_ready), 32'd0);
    c = 1;
    forever begin
      if (c == 1) begin
        if (!c_mux)
          chk(c_size ? "R3 address" : "R2 address", 32'(bus_addr),
              32'(a & (c_size ? 25'h000FFFF : 25'h0FFFFFF)));
        else begin
          chk("R4 address phase", {bus_ale, bus_ad_oe, bus_oe_n, bus_cs_n}, 32'b1110);
          chk("R4 address value", bus_ad_out, 32'(a));
        end
      end
      if (c == 2 && c_mux)
        chk("R4 bus released", {bus_ale, bus_ad_oe, bus_oe_n}, 32'b000);
      if (rsp_valid || c > 200) break;
      if (c == ackat) bus_ack = 1;
      c++;
      @(negedge clk);
    end
    chk(ackat == 0 ? "R5 wait latency" : "R6 ack latency", 32'(c), 32'(exp_lat(ackat)));
    dtag = c_swap ? "R7 data" : (c_mux ? "R4 data" : (c_size ? "R3 data" : "R2 data"));
    chk(dtag, rsp_data, exp_data(d));
    chk("R8 held at done", {bus_cs_n, bus_oe_n}, 32'b00);
    bus_ack = 0;
    @(negedge clk);
    chk("R8 release", {rsp_valid, bus_cs_n, bus_oe_n}, 32'b011);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(4'b0000);
    chk("R9 enable reset value", 32'(cs_enable), 32'h01);
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    en_we = 1; en_wdata = 8'hA4;
    @(negedge clk);
    en_we = 0;
    chk("R9 enable write", 32'(cs_enable), 32'hA4);
    req_valid = 1;
    @(negedge clk);
    chk("R9 boot disabled blocks ready", 32'(req_ready), 32'd0);
    chk("R9 no access started", 32'(bus_cs_n), 32'd1);
    req_valid = 0;
    en_we = 1; en_wdata = 8'h01;
    @(negedge clk);
    en_we = 0;
    chk("R9 boot re-enabled", 32'(req_ready), 32'd1);

    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      chk("R1 sampled straps keep boot enable", 32'(cs_enable), 32'h01);
      txn(25'h1A5C3E7 ^ 25'(s), 32'h8E4D_2B71, 0);
      txn(25'h0F0F0F1 + 25'(s), 32'hC3A5_1F6E, 1);
      txn(25'h155AA33 ^ 25'(s << 4), 32'h7D19_E4B2, 3);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule